// File: doc/BRIEF.md
# Contact Smart Card Power Sequencer

This block brings a contact smart card up and takes it down in a fixed order. A host drives an active-low session command and a reset request. The block turns on the card supply, waits for a supply-good check, puts the data lines into receive mode, and gates the card clock on. After a long run of card clocks it lets the card reset follow the host's request. When the session ends, or when a fault or card removal is seen, it tears the card down in a fixed four-step order with minimum gaps between the steps.

Time is measured against two strobes from the surrounding logic, both synchronous to the system clock. A slow timing tick, nominally 1.5 MHz, paces every window. A one-cycle pulse per card clock period is used to count card clocks. One active-low interrupt line reports card presence while no session is open, and reports a fault while a session is open. The supply regulator, the level shifters and the clock divider are outside this block.

Top module: `card_session_seq`

## Requirements
- R1: A session starts only on a high-to-low transition of `cmdN` that is sampled while `cardPresent` is 1. If `cmdN` is already low when reset is released, or if it stays low after a transition that was ignored because no card was present, no session starts.
- R2: When a session starts, `vccEn` rises at the same edge. `vccOk` is sampled once, when `SUPPLY_TICKS` ticks have passed. If it is 0 at that moment, `irqN` goes low and `vccEn` falls together, and the other outputs stay low.
- R3: If `hostRst` is 0 at the supply check, `rxMode` rises `RX_TICKS` ticks after the check and `cardClkGate` rises `CLK_TICKS` ticks after `rxMode`.
- R4: If `hostRst` is 1 at the supply check, `rxMode` stays 0 until `hostRst` is seen at 0. `cardClkGate` then rises `CLK_TICKS` ticks after `rxMode`.
- R5: `cardRst` stays 0 until `RST_CLKS` card clock pulses have been counted with the clock gated on. From then on it copies `hostRst` one cycle later, even when `hostRst` rose earlier.
- R6: While a session is open, any of the following starts teardown at the next edge: `cmdN` going high, `cardPresent` low, `ocFault`, `otFault` or `vddFault` high, or `vccOk` low once the supply check has passed.
- R7: Teardown lowers `cardRst` after `RSTOFF_TICKS` ticks, then `cardClkGate` after `CLKOFF_TICKS` more ticks, then `rxMode` after `IOOFF_TICKS` more ticks, then `vccEn` after `VCCOFF_TICKS` more ticks.
- R8: While no session is open, `irqN` equals `cardPresent`, and the fault inputs have no effect on any output.
- R9: A fault or a removal inside a session drives `irqN` low at the same edge that teardown starts. `irqN` stays low until `cmdN` is high. Another session then needs a new falling edge of `cmdN`.
- R10: A fault or a removal during the power-up steps, before the clock runs, abandons power-up at once and enters teardown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tickEn | input | 1 | One-cycle timing tick, nominally 1.5 MHz |
| cardClkEn | input | 1 | One-cycle pulse per card clock period |
| cmdN | input | 1 | Active-low session command |
| hostRst | input | 1 | Host card-reset request |
| cardPresent | input | 1 | Card detected |
| vccOk | input | 1 | Card supply within limits |
| ocFault | input | 1 | Card over-current |
| otFault | input | 1 | Over-temperature |
| vddFault | input | 1 | Logic supply low |
| vccEn | output | 1 | Card supply enable |
| rxMode | output | 1 | Data lines in receive mode |
| cardClkGate | output | 1 | Card clock enable |
| cardRst | output | 1 | Card reset line |
| irqN | output | 1 | Active-low presence/fault interrupt |

## Verification
The hardest condition to reach is the moment when `cardRst` is first allowed to follow the host. That moment needs the whole power-up chain to finish, and then the full card-clock count to elapse, while `hostRst` is already high. The bench shortens the tick windows and the clock count through parameters. It raises `hostRst` both before and after the count ends. It then injects single-cycle fault pulses at chosen points of power-up and of the running session. A behavioural model, built from counters and phase numbers, predicts every output on every cycle. This lets the edge where the reset first follows the host, the abort paths and the teardown gaps each be checked exactly.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PWRUP, ST_WAITRST, ST_RXDLY, ST_CLKDLY, ST_RUN,
    ST_OFFRST, ST_OFFCLK, ST_OFFIO, ST_OFFVCC, ST_DONE
  } seqState_e;

  typedef enum logic [2:0] {
    TM_SUPPLY, TM_RXGAP, TM_CLKGAP, TM_RSTOFF, TM_CLKOFF, TM_IOOFF, TM_VCCOFF
  } tmrSel_e;

  typedef struct packed {
    logic    setVcc;
    logic    clrVcc;
    logic    setRx;
    logic    clrRx;
    logic    setClk;
    logic    clrClk;
    logic    clrRst;
    logic    followRst;
    logic    loadTmr;
    tmrSel_e tmrSel;
  } seqStrb_t;

endpackage

// File: rtl/card_seq_ctrl.sv
module card_seq_ctrl
  import card_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdN,
  input  logic     hostRst,
  input  logic     cardPresent,
  input  logic     vccOk,
  input  logic     ocFault,
  input  logic     otFault,
  input  logic     vddFault,
  input  logic     tmrDone,
  output seqStrb_t strb,
  output logic     irqN
);

  seqState_e state, stateNxt;
  logic cmdPrev, faultFlag, setFault, clrFault;
  logic cmdFall, coreFault, vccBad, poweredUp;

  assign cmdFall   = cmdPrev & ~cmdN;
  assign coreFault = ocFault | otFault | vddFault | ~cardPresent;
  assign poweredUp = (state == ST_WAITRST) || (state == ST_RXDLY) ||
                     (state == ST_CLKDLY)  || (state == ST_RUN);
  assign vccBad    = poweredUp & ~vccOk;

  always_comb begin
    stateNxt = state;
    strb     = '0;
    strb.tmrSel = TM_SUPPLY;
    setFault = 1'b0;
    clrFault = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cmdFall && cardPresent) begin
          stateNxt     = ST_PWRUP;
          strb.setVcc  = 1'b1;
          strb.loadTmr = 1'b1;
          strb.tmrSel  = TM_SUPPLY;
        end
      end
      ST_PWRUP: begin
        if (cmdN || coreFault) begin
          stateNxt     = ST_OFFRST;
          strb.loadTmr = 1'b1;
          strb.tmrSel  = TM_RSTOFF;
          setFault     = coreFault;
        end else if (tmrDone) begin
          if (!vccOk) begin
            stateNxt    = ST_DONE;
            strb.clrVcc = 1'b1;
            setFault    = 1'b1;
          end else if (hostRst) begin
            stateNxt = ST_WAITRST;
          end else begin
            stateNxt     = ST_RXDLY;
            strb.loadTmr = 1'b1;
            strb.tmrSel  = TM_RXGAP;
          end
        end
      end
      ST_WAITRST, ST_RXDLY, ST_CLKDLY, ST_RUN: begin
        if (cmdN || coreFault || vccBad) begin
          stateNxt     = ST_OFFRST;
          strb.loadTmr = 1'b1;
          strb.tmrSel  = TM_RSTOFF;
          setFault     = coreFault | vccBad;
        end else begin
          case (state)
            ST_WAITRST: if (!hostRst) begin
              stateNxt     = ST_CLKDLY;
              strb.setRx   = 1'b1;
              strb.loadTmr = 1'b1;
              strb.tmrSel  = TM_CLKGAP;
            end
            ST_RXDLY: if (tmrDone) begin
              stateNxt     = ST_CLKDLY;
              strb.setRx   = 1'b1;
              strb.loadTmr = 1'b1;
              strb.tmrSel  = TM_CLKGAP;
            end
            ST_CLKDLY: if (tmrDone) begin
              stateNxt    = ST_RUN;
              strb.setClk = 1'b1;
            end
            default: strb.followRst = 1'b1;
          endcase
        end
      end
      ST_OFFRST: if (tmrDone) begin
        stateNxt     = ST_OFFCLK;
        strb.clrRst  = 1'b1;
        strb.loadTmr = 1'b1;
        strb.tmrSel  = TM_CLKOFF;
      end
      ST_OFFCLK: if (tmrDone) begin
        stateNxt     = ST_OFFIO;
        strb.clrClk  = 1'b1;
        strb.loadTmr = 1'b1;
        strb.tmrSel  = TM_IOOFF;
      end
      ST_OFFIO: if (tmrDone) begin
        stateNxt     = ST_OFFVCC;
        strb.clrRx   = 1'b1;
        strb.loadTmr = 1'b1;
        strb.tmrSel  = TM_VCCOFF;
      end
      ST_OFFVCC: if (tmrDone) begin
        stateNxt    = ST_DONE;
        strb.clrVcc = 1'b1;
      end
      ST_DONE: if (cmdN) begin
        stateNxt = ST_IDLE;
        clrFault = 1'b1;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      cmdPrev   <= 1'b0;
      faultFlag <= 1'b0;
    end else begin
      state   <= stateNxt;
      cmdPrev <= cmdN;
      if (clrFault)      faultFlag <= 1'b0;
      else if (setFault) faultFlag <= 1'b1;
    end
  end

  assign irqN = (state == ST_IDLE) ? cardPresent : ~faultFlag;

  AST_IDLE_NEEDS_CARD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !cardPresent) |=> (state == ST_IDLE)); // R1
  AST_SUPPLY_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PWRUP && tmrDone && !cmdN && !coreFault && !vccOk)
      |=> (state == ST_DONE && faultFlag)); // R2
  AST_FAULT_TEARDOWN: assert property (@(posedge clk) disable iff (!rstN)
    ((poweredUp || state == ST_PWRUP) && coreFault) |=> (state == ST_OFFRST && !irqN)); // R6
  AST_FAULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (faultFlag && !cmdN) |=> faultFlag); // R9

endmodule

// File: rtl/card_seq_datapath.sv
module card_seq_datapath
  import card_seq_pkg::*;
#(
  parameter int SUPPLY_TICKS = 765,
  parameter int RX_TICKS     = 3,
  parameter int CLK_TICKS    = 1,
  parameter int RSTOFF_TICKS = 1,
  parameter int CLKOFF_TICKS = 12,
  parameter int IOOFF_TICKS  = 1,
  parameter int VCCOFF_TICKS = 1,
  parameter int RST_CLKS     = 42000
)(
  input  logic     clk,
  input  logic     rstN,
  input  logic     tickEn,
  input  logic     cardClkEn,
  input  logic     hostRst,
  input  seqStrb_t strb,
  output logic     tmrDone,
  output logic     vccEn,
  output logic     rxMode,
  output logic     cardClkGate,
  output logic     cardRst
);

  localparam int TMR_SUM = SUPPLY_TICKS + RX_TICKS + CLK_TICKS + RSTOFF_TICKS +
                           CLKOFF_TICKS + IOOFF_TICKS + VCCOFF_TICKS;
  localparam int TMR_W   = $clog2(TMR_SUM + 1);
  localparam int CNT_W   = $clog2(RST_CLKS + 1);
  localparam int NFLOP   = 3;

  logic [TMR_W-1:0] tmrCnt, tmrLoad;
  logic [CNT_W-1:0] clkCnt;
  logic             cntDone;
  logic [NFLOP-1:0] flopSet, flopClr, flopQ;

  always_comb begin
    case (strb.tmrSel)
      TM_SUPPLY: tmrLoad = TMR_W'(SUPPLY_TICKS);
      TM_RXGAP:  tmrLoad = TMR_W'(RX_TICKS);
      TM_CLKGAP: tmrLoad = TMR_W'(CLK_TICKS);
      TM_RSTOFF: tmrLoad = TMR_W'(RSTOFF_TICKS);
      TM_CLKOFF: tmrLoad = TMR_W'(CLKOFF_TICKS);
      TM_IOOFF:  tmrLoad = TMR_W'(IOOFF_TICKS);
      TM_VCCOFF: tmrLoad = TMR_W'(VCCOFF_TICKS);
      default:   tmrLoad = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      tmrCnt <= '0;
    else if (strb.loadTmr)          tmrCnt <= tmrLoad;
    else if (tickEn && tmrCnt != 0) tmrCnt <= tmrCnt - 1'b1;
  end
  assign tmrDone = (tmrCnt == '0);

  // supply, receive mode and clock gate share one set/clear flop shape
  assign flopSet = {strb.setClk, strb.setRx, strb.setVcc};
  assign flopClr = {strb.clrClk, strb.clrRx, strb.clrVcc};

  for (genvar i = 0; i < NFLOP; i++) begin : g_outFlop
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)           flopQ[i] <= 1'b0;
      else if (flopSet[i]) flopQ[i] <= 1'b1;
      else if (flopClr[i]) flopQ[i] <= 1'b0;
    end
  end
  assign vccEn       = flopQ[0];
  assign rxMode      = flopQ[1];
  assign cardClkGate = flopQ[2];

  assign cntDone = (clkCnt == CNT_W'(RST_CLKS));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                     clkCnt <= '0;
    else if (strb.setClk)                          clkCnt <= '0;
    else if (cardClkGate && cardClkEn && !cntDone) clkCnt <= clkCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            cardRst <= 1'b0;
    else if (strb.clrRst)                 cardRst <= 1'b0;
    else if (strb.followRst && cntDone)   cardRst <= hostRst;
  end

  AST_TMR_PARKS: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.loadTmr && tmrDone) |=> tmrDone); // R2
  AST_RX_NEEDS_VCC: assert property (@(posedge clk) disable iff (!rstN)
    rxMode |-> vccEn); // R7
  AST_CLK_NEEDS_RX: assert property (@(posedge clk) disable iff (!rstN)
    cardClkGate |-> rxMode); // R3
  AST_RST_NEEDS_CLK: assert property (@(posedge clk) disable iff (!rstN)
    cardRst |-> cardClkGate); // R7
  AST_RST_AFTER_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cardRst) |-> cntDone); // R5

endmodule

// File: rtl/card_session_seq.sv
module card_session_seq
  import card_seq_pkg::*;
#(
  parameter int SUPPLY_TICKS = 765,
  parameter int RX_TICKS     = 3,
  parameter int CLK_TICKS    = 1,
  parameter int RSTOFF_TICKS = 1,
  parameter int CLKOFF_TICKS = 12,
  parameter int IOOFF_TICKS  = 1,
  parameter int VCCOFF_TICKS = 1,
  parameter int RST_CLKS     = 42000
)(
  input  logic clk,
  input  logic rstN,
  input  logic tickEn,
  input  logic cardClkEn,
  input  logic cmdN,
  input  logic hostRst,
  input  logic cardPresent,
  input  logic vccOk,
  input  logic ocFault,
  input  logic otFault,
  input  logic vddFault,
  output logic vccEn,
  output logic rxMode,
  output logic cardClkGate,
  output logic cardRst,
  output logic irqN
);

  seqStrb_t strb;
  logic     tmrDone;

  card_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdN(cmdN), .hostRst(hostRst),
    .cardPresent(cardPresent), .vccOk(vccOk), .ocFault(ocFault),
    .otFault(otFault), .vddFault(vddFault), .tmrDone(tmrDone),
    .strb(strb), .irqN(irqN)
  );

  card_seq_datapath #(
    .SUPPLY_TICKS(SUPPLY_TICKS), .RX_TICKS(RX_TICKS), .CLK_TICKS(CLK_TICKS),
    .RSTOFF_TICKS(RSTOFF_TICKS), .CLKOFF_TICKS(CLKOFF_TICKS),
    .IOOFF_TICKS(IOOFF_TICKS), .VCCOFF_TICKS(VCCOFF_TICKS), .RST_CLKS(RST_CLKS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cardClkEn(cardClkEn),
    .hostRst(hostRst), .strb(strb), .tmrDone(tmrDone), .vccEn(vccEn),
    .rxMode(rxMode), .cardClkGate(cardClkGate), .cardRst(cardRst)
  );

endmodule

// File: tb/card_session_seq_tb.sv
module card_session_seq_tb;

  localparam int SUP = 6, RXG = 3, CKG = 1, D1 = 1, D2 = 12, D3 = 1, D4 = 1, NCLK = 40;

  logic clk = 1'b0, rstN = 1'b0;
  logic tickEn = 1'b0, cardClkEn = 1'b0;
  logic cmdN = 1'b1, hostRst = 1'b0, cardPresent = 1'b0, vccOk = 1'b1;
  logic ocFault = 1'b0, otFault = 1'b0, vddFault = 1'b0;
  logic vccEn, rxMode, cardClkGate, cardRst, irqN;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  card_session_seq #(
    .SUPPLY_TICKS(SUP), .RX_TICKS(RXG), .CLK_TICKS(CKG), .RSTOFF_TICKS(D1),
    .CLKOFF_TICKS(D2), .IOOFF_TICKS(D3), .VCCOFF_TICKS(D4), .RST_CLKS(NCLK)
  ) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .cardClkEn(cardClkEn),
    .cmdN(cmdN), .hostRst(hostRst), .cardPresent(cardPresent), .vccOk(vccOk),
    .ocFault(ocFault), .otFault(otFault), .vddFault(vddFault),
    .vccEn(vccEn), .rxMode(rxMode), .cardClkGate(cardClkGate),
    .cardRst(cardRst), .irqN(irqN)
  );

  // behavioural reference: phase number plus remaining-tick and clock counters
  int mPh = 0, mTicks = 0, mClks = 0;
  bit mVcc = 0, mRx = 0, mClk = 0, mRst = 0, mFlt = 0, mPrev = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mPh = 0; mTicks = 0; mClks = 0;
      mVcc = 0; mRx = 0; mClk = 0; mRst = 0; mFlt = 0; mPrev = 0;
    end else begin
      bit fall, flt, done, cdone, follow, startClk, oldClk;
      int load, nextPh;
      fall = mPrev && !cmdN; mPrev = cmdN;
      flt = ocFault || otFault || vddFault || !cardPresent;
      done = (mTicks == 0); cdone = (mClks == NCLK); oldClk = mClk;
      load = -1; follow = 0; startClk = 0; nextPh = mPh;
      if (mPh == 0) begin
        if (fall && cardPresent) begin nextPh = 1; mVcc = 1; load = SUP; end
      end else if (mPh == 1) begin
        if (cmdN || flt) begin nextPh = 6; load = D1; if (flt) mFlt = 1; end
        else if (done) begin
          if (!vccOk) begin nextPh = 10; mFlt = 1; mVcc = 0; end
          else if (hostRst) nextPh = 2;
          else begin nextPh = 3; load = RXG; end
        end
      end else if (mPh >= 2 && mPh <= 5) begin
        if (cmdN || flt || !vccOk) begin
          nextPh = 6; load = D1; if (flt || !vccOk) mFlt = 1;
        end else if (mPh == 2) begin
          if (!hostRst) begin nextPh = 4; mRx = 1; load = CKG; end
        end else if (mPh == 3) begin
          if (done) begin nextPh = 4; mRx = 1; load = CKG; end
        end else if (mPh == 4) begin
          if (done) begin nextPh = 5; startClk = 1; end
        end else follow = 1;
      end else if (mPh == 6) begin
        if (done) begin mRst = 0; nextPh = 7; load = D2; end
      end else if (mPh == 7) begin
        if (done) begin mClk = 0; nextPh = 8; load = D3; end
      end else if (mPh == 8) begin
        if (done) begin mRx = 0; nextPh = 9; load = D4; end
      end else if (mPh == 9) begin
        if (done) begin mVcc = 0; nextPh = 10; end
      end else begin
        if (cmdN) begin nextPh = 0; mFlt = 0; end
      end
      if (follow && cdone) mRst = hostRst;
      if (startClk) begin mClk = 1; mClks = 0; end
      else if (oldClk && cardClkEn && !cdone) mClks++;
      if (load >= 0) mTicks = load;
      else if (tickEn && mTicks > 0) mTicks--;
      mPh = nextPh;
    end
  end

  task automatic cmp(string req, string name, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b exp %0b at %0t", req, name, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && !finished) begin
      cmp("R2", "vccEn", vccEn, mVcc);
      cmp("R3", "rxMode", rxMode, mRx);
      cmp("R3", "cardClkGate", cardClkGate, mClk);
      cmp("R5", "cardRst", cardRst, mRst);
      cmp("R9", "irqN", irqN, (mPh == 0) ? cardPresent : !mFlt);
    end
  end

  // free-running strobes: tick every third cycle, card clock every second
  initial begin
    int n = 0;
    forever begin
      @(negedge clk); #1;
      n++;
      tickEn = (n % 3 == 0);
      cardClkEn = (n % 2 == 0);
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic faultRun(int kind);
    cmdN = 1'b1; step(3);
    cmdN = 1'b0; step(150);
    case (kind)
      0: otFault = 1'b1;
      1: vddFault = 1'b1;
      2: vccOk = 1'b0;
      default: cardPresent = 1'b0;
    endcase
    step(1);
    otFault = 1'b0; vddFault = 1'b0; vccOk = 1'b1; cardPresent = 1'b1;
    step(1);
    cmp("R6", "irqN after fault", irqN, 1'b0);
    step(80);
    cmp("R6", "vccEn after teardown", vccEn, 1'b0);
    cmdN = 1'b1; step(3);
  endtask

  initial begin
    int tR, tC, tX, tV;
    step(5);
    rstN = 1'b1;
    step(2);
    cmp("R8", "irqN no card", irqN, 1'b0);
    cmp("R8", "vccEn after reset", vccEn, 1'b0);

    // R1: falling edge with no card, then card arrives with command held low
    cmdN = 1'b0; step(5);
    cardPresent = 1'b1; step(30);
    cmp("R1", "vccEn held-low command", vccEn, 1'b0);
    cmp("R8", "irqN card present", irqN, 1'b1);
    cmdN = 1'b1; step(3);

    // R8: faults outside a session
    otFault = 1'b1; vddFault = 1'b1; ocFault = 1'b1; step(5);
    cmp("R8", "irqN faults idle", irqN, 1'b1);
    cmp("R8", "vccEn faults idle", vccEn, 1'b0);
    otFault = 1'b0; vddFault = 1'b0; ocFault = 1'b0; step(2);

    // R3 and R5: host reset low at the check, then raised after the count
    hostRst = 1'b0; cmdN = 1'b0; step(200);
    cmp("R3", "cardClkGate running", cardClkGate, 1'b1);
    cmp("R5", "cardRst follows low", cardRst, 1'b0);
    hostRst = 1'b1; step(3);
    cmp("R5", "cardRst follows high", cardRst, 1'b1);

    // R7: teardown order and gap
    cmdN = 1'b1; tR = -1; tC = -1; tX = -1; tV = -1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (tR < 0 && !cardRst) tR = i;
      if (tC < 0 && !cardClkGate) tC = i;
      if (tX < 0 && !rxMode) tX = i;
      if (tV < 0 && !vccEn) tV = i;
    end
    #2;
    checks++;
    if (!(tR >= 0 && tR < tC && tC < tX && tX < tV && (tC - tR) >= 33)) begin
      errors++;
      $display("FAIL R7 order rst=%0d clk=%0d io=%0d vcc=%0d exp increasing, clk gap>=33",
               tR, tC, tX, tV);
    end

    // R4 and R5: host reset high at the check, raised early again
    hostRst = 1'b1; cmdN = 1'b0; step(60);
    cmp("R4", "rxMode waits for host reset", rxMode, 1'b0);
    hostRst = 1'b0; step(5);
    cmp("R4", "rxMode after host reset low", rxMode, 1'b1);
    hostRst = 1'b1; step(10);
    cmp("R5", "cardRst before count", cardRst, 1'b0);
    step(100);
    cmp("R5", "cardRst after count", cardRst, 1'b1);

    // R6 and R9: over-current pulse, interrupt held until command high
    ocFault = 1'b1; step(1); ocFault = 1'b0; step(1);
    cmp("R9", "irqN on fault", irqN, 1'b0);
    step(100);
    cmp("R9", "irqN held", irqN, 1'b0);
    cmp("R9", "no restart without new edge", vccEn, 1'b0);
    cmdN = 1'b1; step(3);
    cmp("R8", "irqN back to presence", irqN, 1'b1);
    cmdN = 1'b0; step(4);
    cmp("R9", "fresh edge restarts", vccEn, 1'b1);
    cmdN = 1'b1; step(80);

    // R2: supply never good
    vccOk = 1'b0; cmdN = 1'b0; step(40);
    cmp("R2", "irqN supply fail", irqN, 1'b0);
    cmp("R2", "vccEn supply fail", vccEn, 1'b0);
    cmdN = 1'b1; vccOk = 1'b1; step(3);

    // R10: removal during power-up
    cmdN = 1'b0; step(8);
    cardPresent = 1'b0; step(1); cardPresent = 1'b1; step(1);
    cmp("R10", "irqN abort", irqN, 1'b0);
    step(80);
    cmp("R10", "vccEn abort", vccEn, 1'b0);
    cmp("R10", "rxMode abort", rxMode, 1'b0);
    cmdN = 1'b1; step(3);

    // R6: remaining triggers
    hostRst = 1'b0;
    for (int k = 0; k < 4; k++) faultRun(k);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog expired got hang exp completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule